// File: doc/BRIEF.md
# Paravirtual device common configuration register file

This block is the common configuration window of a paravirtual I/O device, reached through a memory-mapped slave port. The port is little-endian. It accepts naturally aligned accesses of 1, 2 or 4 bytes, and each read answers one cycle after its request. Two 32-bit select registers page the 64-bit device feature input and the 64-bit driver feature word through 32-bit data windows. The block also holds the device status byte and the configuration interrupt vector.

A queue-select register chooses one of a bank of per-queue register sets. Each set holds:
- a size,
- an interrupt vector,
- an enable flag,
- three 64-bit ring addresses, written as separate low and high words.

Size and ring addresses are staged. They reach the queue outputs only when the driver writes the queue's enable register. A status write that leaves the status at zero pulses a device reset and returns every interrupt vector to the "no vector" code.

The register words, with byte offsets in hexadecimal, are:

| Offset | Bytes 3..2 | Bytes 1..0 |
|--------|------------|------------|
| 00 | device feature select (all 4 bytes) | |
| 04 | device feature data (all 4 bytes) | |
| 08 | driver feature select (all 4 bytes) | |
| 0C | driver feature data (all 4 bytes) | |
| 10 | queue count (read-only) | config vector |
| 14 | queue select | byte 1: generation (reads 0); byte 0: status |
| 18 | queue vector | queue size |
| 1C | notify offset (read-only) | queue enable |
| 20 / 24 | descriptor ring address, high word at 24 | low word at 20 |
| 28 / 2C | available ring address, high word at 2C | low word at 28 |
| 30 / 34 | used ring address, high word at 34 | low word at 30 |

Top module: `vq_common_cfg`

## Requirements
- R1: Reading the device feature data word (0x04) returns dev_feat_i[31:0] when the device feature select (0x00) holds 0, dev_feat_i[63:32] when it holds 1, and 0 for any other select value. The select word reads back as written.
- R2: Writing the driver feature data word (0x0C) updates the half chosen by the driver feature select (0x08): half 0 when the select is 0, half 1 when it is 1. drv_feat_o is {half1, half0}. For a select of 2 or more, the write changes nothing and the data word reads 0.
- R3: A write to queue select (0x16, 16 bits) takes effect only when the written value is below NUM_Q. Otherwise the previous selection stays.
- R4: The queue count (0x12) reads one plus the highest queue index whose committed size is nonzero, or 0 when no committed size is nonzero. Queue size (0x18) reads the committed size of the selected queue.
- R5: The notify offset (0x1E) reads the selected queue index, and writes to it are ignored.
- R6: Each ring address of the selected queue is staged as a low word and a high word at the offsets above, and reads back from the staging registers.
- R7: A write to any of bytes 0..1 of word 0x1C commits the selected queue's staged size and its three ring addresses ({high,low}) to q_size_o, q_desc_o, q_avail_o and q_used_o. In the cycle those outputs change, the queue's bit of q_commit_o is high for one cycle. Bit 0 of the written byte sets q_en_o. Outputs of other queues are untouched.
- R8: A status write (byte 0x14) stores the written byte in status_o. If that byte is 0, then in the cycle after the write:
  - dev_reset_o is high for one cycle;
  - the config vector and all queue vectors become 0xFFFF;
  - all q_en_o bits clear.
  Committed sizes and addresses are kept.
- R9: A written config vector (0x10) or queue vector (0x1A) is stored only if it is below NUM_VEC. Otherwise 0xFFFF is stored.
- R10: The generation byte (0x15) reads 0. Offsets 0x38 and above read 0 and ignore writes. Writes to the read-only fields (0x04, 0x12, 0x1E) change nothing.
- R11: Size code 0 selects 1 byte, 1 selects 2 bytes, and 2 or 3 selects 4 bytes. Byte address a carries register byte a mod 4. Write data and read data are right-justified. A write changes only the addressed bytes. rsp_valid_o rises exactly one cycle after each read request.
- R12: After reset:
  - status, drv_feat_o, q_en_o, all committed outputs and the queue count are 0;
  - the config vector and the queue vectors are 0xFFFF;
  - dev_reset_o and q_commit_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Access request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_size_i | input | 2 | Access size code (0: 1 B, 1: 2 B, 2/3: 4 B) |
| req_wdata_i | input | 32 | Right-justified write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Right-justified read data |
| dev_feat_i | input | 64 | Device feature bits offered |
| drv_feat_o | output | 64 | Driver feature bits accepted |
| status_o | output | 8 | Device status byte |
| dev_reset_o | output | 1 | One-cycle device reset pulse |
| cfg_vec_o | output | 16 | Configuration interrupt vector |
| q_commit_o | output | NUM_Q | Per-queue commit pulse |
| q_en_o | output | NUM_Q | Per-queue enable flag |
| q_vec_o | output | NUM_Q x 16 | Per-queue interrupt vector |
| q_size_o | output | NUM_Q x 16 | Committed queue size |
| q_desc_o | output | NUM_Q x 64 | Committed descriptor ring address |
| q_avail_o | output | NUM_Q x 64 | Committed available ring address |
| q_used_o | output | NUM_Q x 64 | Committed used ring address |

## Verification
The bench builds the block with NUM_Q = 3 and NUM_VEC = 5. With three queues, a select of 3 fits in the two select bits yet must still be refused, so the bound check cannot pass by bit truncation alone. With five vectors, the grant boundary at 4 and the first refused value 5 are both only a few writes away. With a queue count that is not a power of two, the highest-committed-index count can be exercised on the last queue and on a lower one.

// File: rtl/vq_cfg_pkg.sv
// Package: shared word map, bus write record, ring record and helpers.
// Assumes a 32-bit register word; word indices are byte offset / 4.
package vq_cfg_pkg;

    localparam logic [15:0] NO_VECTOR = 16'hFFFF;
    localparam int unsigned MAP_WORDS = 14;

    typedef enum logic [3:0] {
        W_DFSEL    = 4'd0,
        W_DF       = 4'd1,
        W_GFSEL    = 4'd2,
        W_GF       = 4'd3,
        W_CFGVEC   = 4'd4,
        W_STATSEL  = 4'd5,
        W_QSIZEVEC = 4'd6,
        W_QENNOTE  = 4'd7,
        W_DESC_LO  = 4'd8,
        W_DESC_HI  = 4'd9,
        W_AVAIL_LO = 4'd10,
        W_AVAIL_HI = 4'd11,
        W_USED_LO  = 4'd12,
        W_USED_HI  = 4'd13,
        W_NONE     = 4'd15
    } word_e;

    typedef struct packed {
        logic        en;
        word_e       word;
        logic [3:0]  be;
        logic [31:0] data;
    } bus_wr_t;

    typedef struct packed {
        logic [15:0] size;
        logic [63:0] desc;
        logic [63:0] avail;
        logic [63:0] used;
    } ring_cfg_t;

    // Byte-enable merge of a 32-bit register.
    function automatic logic [31:0] merge32(input logic [31:0] old,
                                            input logic [31:0] nw,
                                            input logic [3:0]  be);
        logic [31:0] r;
        r = old;
        for (int b = 0; b < 4; b++) begin
            if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
        end
        return r;
    endfunction

    // Byte-enable merge of a 16-bit register.
    function automatic logic [15:0] merge16(input logic [15:0] old,
                                            input logic [15:0] nw,
                                            input logic [1:0]  be);
        logic [15:0] r;
        r = old;
        if (be[0]) r[7:0]  = nw[7:0];
        if (be[1]) r[15:8] = nw[15:8];
        return r;
    endfunction

    // Vector allocation: values at or above the vector count are refused.
    function automatic logic [15:0] grant_vec(input logic [15:0] req,
                                              input int unsigned nvec);
        return (32'(req) < nvec) ? req : NO_VECTOR;
    endfunction

endpackage

// File: rtl/vq_feature_win.sv
// Feature window: device-feature paging and driver-feature capture.
// Assumes write records are already decoded to word index and byte enables.
module vq_feature_win
    import vq_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  bus_wr_t     wr,
    input  word_e       rd_word,
    input  logic [63:0] dev_feat_i,
    output logic [31:0] rd_data,
    output logic [63:0] drv_feat_o
);

    logic [31:0]       dev_sel;
    logic [31:0]       drv_sel;
    logic [1:0][31:0]  drv_half;

    // Select registers for both windows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_sel <= '0;
            drv_sel <= '0;
        end else if (wr.en) begin
            if (wr.word == W_DFSEL) dev_sel <= merge32(dev_sel, wr.data, wr.be);
            if (wr.word == W_GFSEL) drv_sel <= merge32(drv_sel, wr.data, wr.be);
        end
    end

    // One capture register per driver-feature half.
    for (genvar h = 0; h < 2; h++) begin : g_half
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                drv_half[h] <= '0;
            end else if (wr.en && wr.word == W_GF && drv_sel == 32'(h)) begin
                drv_half[h] <= merge32(drv_half[h], wr.data, wr.be);
            end
        end
    end

    assign drv_feat_o = {drv_half[1], drv_half[0]};

    // Read contribution for the four feature words.
    always_comb begin
        rd_data = '0;
        case (rd_word)
            W_DFSEL: rd_data = dev_sel;
            W_DF: begin
                if (dev_sel == 32'd0)      rd_data = dev_feat_i[31:0];
                else if (dev_sel == 32'd1) rd_data = dev_feat_i[63:32];
            end
            W_GFSEL: rd_data = drv_sel;
            W_GF: begin
                if (drv_sel < 32'd2) rd_data = drv_half[drv_sel[0]];
            end
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/vq_status_vec.sv
// Status byte and configuration vector, plus the device reset request.
// Assumes status occupies byte 0 of its word and the vector bytes 0..1.
module vq_status_vec
    import vq_cfg_pkg::*;
#(
    parameter int unsigned NUM_VEC = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  bus_wr_t     wr,
    input  word_e       rd_word,
    output logic [31:0] rd_data,
    output logic        reset_req,
    output logic [7:0]  status_o,
    output logic [15:0] cfg_vec_o,
    output logic        dev_reset_o
);

    logic stat_wr;
    logic vec_wr;

    assign stat_wr   = wr.en && wr.word == W_STATSEL && wr.be[0];
    assign vec_wr    = wr.en && wr.word == W_CFGVEC && (|wr.be[1:0]);
    assign reset_req = stat_wr && (wr.data[7:0] == 8'h00);

    // Status byte capture.
    always_ff @(posedge clk) begin
        if (!rst_n)       status_o <= '0;
        else if (stat_wr) status_o <= wr.data[7:0];
    end

    // Configuration vector with allocation check and release on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_vec_o <= NO_VECTOR;
        else if (reset_req)
            cfg_vec_o <= NO_VECTOR;
        else if (vec_wr)
            cfg_vec_o <= grant_vec(merge16(cfg_vec_o, wr.data[15:0], wr.be[1:0]), NUM_VEC);
    end

    // One-cycle device reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) dev_reset_o <= 1'b0;
        else        dev_reset_o <= reset_req;
    end

    // Read contribution: vector low half, status byte; generation byte is 0.
    always_comb begin
        case (rd_word)
            W_CFGVEC:  rd_data = {16'h0000, cfg_vec_o};
            W_STATSEL: rd_data = {24'h000000, status_o};
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/vq_queue_bank.sv
// Queue bank: select register, staged and committed per-queue settings.
// Assumes NUM_Q >= 2 so the select index has at least one bit.
module vq_queue_bank
    import vq_cfg_pkg::*;
#(
    parameter int unsigned NUM_Q   = 4,
    parameter int unsigned NUM_VEC = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  bus_wr_t                 wr,
    input  word_e                   rd_word,
    input  logic                    reset_req,
    output logic [31:0]             rd_data,
    output logic [NUM_Q-1:0]        q_commit_o,
    output logic [NUM_Q-1:0]        q_en_o,
    output logic [NUM_Q-1:0][15:0]  q_vec_o,
    output logic [NUM_Q-1:0][15:0]  q_size_o,
    output logic [NUM_Q-1:0][63:0]  q_desc_o,
    output logic [NUM_Q-1:0][63:0]  q_avail_o,
    output logic [NUM_Q-1:0][63:0]  q_used_o
);

    localparam int unsigned QSEL_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

    logic [QSEL_W-1:0]        qsel;
    logic [15:0]              qsel_ext;
    logic [15:0]              qsel_cand;
    logic [15:0]              nq;
    logic [NUM_Q-1:0][63:0]   stg_desc;
    logic [NUM_Q-1:0][63:0]   stg_avail;
    logic [NUM_Q-1:0][63:0]   stg_used;

    assign qsel_ext = 16'(qsel);

    // Candidate selection after the byte merge.
    always_comb begin
        qsel_cand = merge16(qsel_ext, wr.data[31:16], wr.be[3:2]);
    end

    // Queue select: accepted only when inside the bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qsel <= '0;
        end else if (wr.en && wr.word == W_STATSEL && (|wr.be[3:2])) begin
            if (32'(qsel_cand) < NUM_Q) qsel <= qsel_cand[QSEL_W-1:0];
        end
    end

    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        ring_cfg_t   stg;
        ring_cfg_t   cmt;
        logic [15:0] vec;
        logic        en;
        logic        commit;
        logic        hit;

        assign hit = wr.en && (qsel == QSEL_W'(q));

        // Staging, vector, enable flag and commit for one queue.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg    <= '0;
                cmt    <= '0;
                vec    <= NO_VECTOR;
                en     <= 1'b0;
                commit <= 1'b0;
            end else begin
                commit <= 1'b0;
                if (hit) begin
                    case (wr.word)
                        W_QSIZEVEC: begin
                            if (|wr.be[1:0])
                                stg.size <= merge16(stg.size, wr.data[15:0], wr.be[1:0]);
                            if (|wr.be[3:2])
                                vec <= grant_vec(merge16(vec, wr.data[31:16], wr.be[3:2]), NUM_VEC);
                        end
                        W_QENNOTE: begin
                            if (|wr.be[1:0]) begin
                                cmt    <= stg;
                                commit <= 1'b1;
                                if (wr.be[0]) en <= wr.data[0];
                            end
                        end
                        W_DESC_LO:  stg.desc[31:0]   <= merge32(stg.desc[31:0],   wr.data, wr.be);
                        W_DESC_HI:  stg.desc[63:32]  <= merge32(stg.desc[63:32],  wr.data, wr.be);
                        W_AVAIL_LO: stg.avail[31:0]  <= merge32(stg.avail[31:0],  wr.data, wr.be);
                        W_AVAIL_HI: stg.avail[63:32] <= merge32(stg.avail[63:32], wr.data, wr.be);
                        W_USED_LO:  stg.used[31:0]   <= merge32(stg.used[31:0],   wr.data, wr.be);
                        W_USED_HI:  stg.used[63:32]  <= merge32(stg.used[63:32],  wr.data, wr.be);
                        default: ;
                    endcase
                end
                if (reset_req) begin
                    vec <= NO_VECTOR;
                    en  <= 1'b0;
                end
            end
        end

        assign q_commit_o[q] = commit;
        assign q_en_o[q]     = en;
        assign q_vec_o[q]    = vec;
        assign q_size_o[q]   = cmt.size;
        assign q_desc_o[q]   = cmt.desc;
        assign q_avail_o[q]  = cmt.avail;
        assign q_used_o[q]   = cmt.used;
        assign stg_desc[q]   = stg.desc;
        assign stg_avail[q]  = stg.avail;
        assign stg_used[q]   = stg.used;
    end

    // Queue count: one past the highest queue with a committed size.
    always_comb begin
        nq = '0;
        for (int i = 0; i < NUM_Q; i++) begin
            if (q_size_o[i] != 16'h0000) nq = 16'(i + 1);
        end
    end

    // Read contribution of the bank words.
    always_comb begin
        case (rd_word)
            W_CFGVEC:   rd_data = {nq, 16'h0000};
            W_STATSEL:  rd_data = {qsel_ext, 16'h0000};
            W_QSIZEVEC: rd_data = {q_vec_o[qsel], q_size_o[qsel]};
            W_QENNOTE:  rd_data = {qsel_ext, 15'h0000, q_en_o[qsel]};
            W_DESC_LO:  rd_data = stg_desc[qsel][31:0];
            W_DESC_HI:  rd_data = stg_desc[qsel][63:32];
            W_AVAIL_LO: rd_data = stg_avail[qsel][31:0];
            W_AVAIL_HI: rd_data = stg_avail[qsel][63:32];
            W_USED_LO:  rd_data = stg_used[qsel][31:0];
            W_USED_HI:  rd_data = stg_used[qsel][63:32];
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/vq_common_cfg.sv
// Top: access decode into byte lanes, read alignment and response register.
// Assumes naturally aligned accesses; bytes past the word end are dropped.
module vq_common_cfg
    import vq_cfg_pkg::*;
#(
    parameter int unsigned NUM_Q   = 4,
    parameter int unsigned NUM_VEC = 8,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid_i,
    input  logic                    req_write_i,
    input  logic [ADDR_W-1:0]       req_addr_i,
    input  logic [1:0]              req_size_i,
    input  logic [31:0]             req_wdata_i,
    output logic                    rsp_valid_o,
    output logic [31:0]             rsp_rdata_o,
    input  logic [63:0]             dev_feat_i,
    output logic [63:0]             drv_feat_o,
    output logic [7:0]              status_o,
    output logic                    dev_reset_o,
    output logic [15:0]             cfg_vec_o,
    output logic [NUM_Q-1:0]        q_commit_o,
    output logic [NUM_Q-1:0]        q_en_o,
    output logic [NUM_Q-1:0][15:0]  q_vec_o,
    output logic [NUM_Q-1:0][15:0]  q_size_o,
    output logic [NUM_Q-1:0][63:0]  q_desc_o,
    output logic [NUM_Q-1:0][63:0]  q_avail_o,
    output logic [NUM_Q-1:0][63:0]  q_used_o
);

    localparam int unsigned WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] word_raw;
    logic [1:0]        byte_ofs;
    logic [3:0]        size_mask;
    logic [31:0]       rd_mask;
    word_e             word;
    bus_wr_t           wr;
    logic [31:0]       fw_rd;
    logic [31:0]       sv_rd;
    logic [31:0]       qb_rd;
    logic [31:0]       rd_word_data;
    logic              reset_req;

    assign word_raw = req_addr_i[ADDR_W-1:2];
    assign byte_ofs = req_addr_i[1:0];

    // Decode: word index, byte enables and lane-aligned data.
    always_comb begin
        case (req_size_i)
            2'd0:    begin size_mask = 4'b0001; rd_mask = 32'h0000_00FF; end
            2'd1:    begin size_mask = 4'b0011; rd_mask = 32'h0000_FFFF; end
            default: begin size_mask = 4'b1111; rd_mask = 32'hFFFF_FFFF; end
        endcase
        word    = (32'(word_raw) < MAP_WORDS) ? word_e'(word_raw[3:0]) : W_NONE;
        wr.en   = req_valid_i && req_write_i && (word != W_NONE);
        wr.word = word;
        wr.be   = size_mask << byte_ofs;
        wr.data = req_wdata_i << {byte_ofs, 3'b000};
    end

    vq_feature_win u_feat (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (wr),
        .rd_word    (word),
        .dev_feat_i (dev_feat_i),
        .rd_data    (fw_rd),
        .drv_feat_o (drv_feat_o)
    );

    vq_status_vec #(.NUM_VEC(NUM_VEC)) u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (wr),
        .rd_word     (word),
        .rd_data     (sv_rd),
        .reset_req   (reset_req),
        .status_o    (status_o),
        .cfg_vec_o   (cfg_vec_o),
        .dev_reset_o (dev_reset_o)
    );

    vq_queue_bank #(.NUM_Q(NUM_Q), .NUM_VEC(NUM_VEC)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (wr),
        .rd_word    (word),
        .reset_req  (reset_req),
        .rd_data    (qb_rd),
        .q_commit_o (q_commit_o),
        .q_en_o     (q_en_o),
        .q_vec_o    (q_vec_o),
        .q_size_o   (q_size_o),
        .q_desc_o   (q_desc_o),
        .q_avail_o  (q_avail_o),
        .q_used_o   (q_used_o)
    );

    assign rd_word_data = fw_rd | sv_rd | qb_rd;

    // Read response: one cycle after the request, right-justified.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_o <= 1'b0;
            rsp_rdata_o <= '0;
        end else begin
            rsp_valid_o <= req_valid_i && !req_write_i;
            if (req_valid_i && !req_write_i)
                rsp_rdata_o <= (rd_word_data >> {byte_ofs, 3'b000}) & rd_mask;
        end
    end

endmodule

// File: rtl/vq_common_cfg_chk.sv
// Checker: temporal properties of the register file, bound to the top.
// Assumes it sees only the top's ports.
module vq_common_cfg_chk #(
    parameter int unsigned NUM_Q   = 4,
    parameter int unsigned NUM_VEC = 8,
    parameter int unsigned ADDR_W  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid_i,
    input logic                    req_write_i,
    input logic [ADDR_W-1:0]       req_addr_i,
    input logic                    rsp_valid_o,
    input logic [63:0]             drv_feat_o,
    input logic [7:0]              status_o,
    input logic                    dev_reset_o,
    input logic [15:0]             cfg_vec_o,
    input logic [NUM_Q-1:0]        q_commit_o,
    input logic [NUM_Q-1:0]        q_en_o,
    input logic [NUM_Q-1:0][15:0]  q_vec_o,
    input logic [NUM_Q-1:0][15:0]  q_size_o,
    input logic [NUM_Q-1:0][63:0]  q_desc_o,
    input logic [NUM_Q-1:0][63:0]  q_avail_o,
    input logic [NUM_Q-1:0][63:0]  q_used_o
);

    logic wr_any;
    logic wr_gf;
    logic wr_stat;
    logic wr_en_lo;
    logic rd_req;

    assign wr_any   = req_valid_i && req_write_i;
    assign rd_req   = req_valid_i && !req_write_i;
    assign wr_gf    = wr_any && req_addr_i[ADDR_W-1:2] == (ADDR_W-2)'(3);
    assign wr_stat  = wr_any && req_addr_i[ADDR_W-1:2] == (ADDR_W-2)'(5) && req_addr_i[1:0] == 2'd0;
    assign wr_en_lo = wr_any && req_addr_i[ADDR_W-1:2] == (ADDR_W-2)'(7) && !req_addr_i[1];

    assert_reset_state_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (status_o == 8'h00 && cfg_vec_o == 16'hFFFF && q_en_o == '0 && drv_feat_o == '0));

    assert_drv_feat_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(drv_feat_o) |-> $past(wr_gf));

    assert_commit_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q_commit_o));

    assert_commit_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|q_commit_o) |-> $past(wr_en_lo));

    for (genvar q = 0; q < NUM_Q; q++) begin : g_chk
        assert_commit_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!$stable(q_size_o[q]) || !$stable(q_desc_o[q]) ||
             !$stable(q_avail_o[q]) || !$stable(q_used_o[q])) |-> q_commit_o[q]);

        assert_qvec_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (32'(q_vec_o[q]) < NUM_VEC) || (q_vec_o[q] == 16'hFFFF));
    end

    assert_cfgvec_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(cfg_vec_o) < NUM_VEC) || (cfg_vec_o == 16'hFFFF));

    assert_reset_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset_o |-> (status_o == 8'h00 && cfg_vec_o == 16'hFFFF && q_en_o == '0));

    assert_status_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_o) |-> $past(wr_stat));

    assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid_o);

    assert_rsp_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(rd_req));

endmodule

bind vq_common_cfg vq_common_cfg_chk #(
    .NUM_Q   (NUM_Q),
    .NUM_VEC (NUM_VEC),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .rsp_valid_o (rsp_valid_o),
    .drv_feat_o  (drv_feat_o),
    .status_o    (status_o),
    .dev_reset_o (dev_reset_o),
    .cfg_vec_o   (cfg_vec_o),
    .q_commit_o  (q_commit_o),
    .q_en_o      (q_en_o),
    .q_vec_o     (q_vec_o),
    .q_size_o    (q_size_o),
    .q_desc_o    (q_desc_o),
    .q_avail_o   (q_avail_o),
    .q_used_o    (q_used_o)
);

// File: tb/tb_vq_common_cfg.sv
// Scoreboard bench: read tasks push expected data, a monitor pops and compares.
module tb_vq_common_cfg;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned NQ = 3;
    localparam int unsigned NV = 5;
    localparam int unsigned AW = 8;
    localparam logic [63:0] DEV_FEAT = 64'hFEED_0001_1234_5678;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req_valid = 1'b0;
    logic                 req_write = 1'b0;
    logic [AW-1:0]        req_addr = '0;
    logic [1:0]           req_size = '0;
    logic [31:0]          req_wdata = '0;
    logic                 rsp_valid;
    logic [31:0]          rsp_rdata;
    logic [63:0]          drv_feat;
    logic [7:0]           status;
    logic                 dev_reset;
    logic [15:0]          cfg_vec;
    logic [NQ-1:0]        q_commit;
    logic [NQ-1:0]        q_en;
    logic [NQ-1:0][15:0]  q_vec;
    logic [NQ-1:0][15:0]  q_size;
    logic [NQ-1:0][63:0]  q_desc;
    logic [NQ-1:0][63:0]  q_avail;
    logic [NQ-1:0][63:0]  q_used;

    int n_chk = 0;
    int n_err = 0;
    logic done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vq_common_cfg #(.NUM_Q(NQ), .NUM_VEC(NV), .ADDR_W(AW)) dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid_i (req_valid), .req_write_i (req_write), .req_addr_i (req_addr),
        .req_size_i (req_size), .req_wdata_i (req_wdata),
        .rsp_valid_o (rsp_valid), .rsp_rdata_o (rsp_rdata),
        .dev_feat_i (DEV_FEAT), .drv_feat_o (drv_feat), .status_o (status),
        .dev_reset_o (dev_reset), .cfg_vec_o (cfg_vec), .q_commit_o (q_commit),
        .q_en_o (q_en), .q_vec_o (q_vec), .q_size_o (q_size), .q_desc_o (q_desc),
        .q_avail_o (q_avail), .q_used_o (q_used)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] exp,
                      input string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compare each read response with the head of the scoreboard.
    always @(negedge clk) begin
        if (rsp_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_err++;
                $display("FAIL R11 unexpected response actual=%h expected=none", rsp_rdata);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(t, 64'(rsp_rdata), 64'(e));
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        chk("R12 status", 64'(status), 64'h0);
        chk("R12 cfg vector", 64'(cfg_vec), 64'hFFFF);
        chk("R12 driver features", drv_feat, 64'h0);
        chk("R12 enables", 64'(q_en), 64'h0);
        chk("R12 reset pulse", 64'(dev_reset), 64'h0);
        chk("R12 commit pulse", 64'(q_commit), 64'h0);
        rd(8'h10, 2'd2, 32'h0000_FFFF, "R12 queue count and cfg vector");
        rd(8'h1A, 2'd1, 32'h0000_FFFF, "R12 queue vector");

        // R1: device feature window
        wr(8'h00, 2'd2, 32'd0);
        rd(8'h04, 2'd2, 32'h1234_5678, "R1 low half");
        wr(8'h00, 2'd2, 32'd1);
        rd(8'h04, 2'd2, 32'hFEED_0001, "R1 high half");
        rd(8'h06, 2'd1, 32'h0000_FEED, "R11 two-byte read upper lanes");
        wr(8'h00, 2'd2, 32'd2);
        rd(8'h04, 2'd2, 32'h0, "R1 out-of-range select");
        rd(8'h00, 2'd2, 32'd2, "R1 select readback");

        // R2: driver feature capture
        wr(8'h08, 2'd2, 32'd1);
        wr(8'h0C, 2'd2, 32'hCAFE_F00D);
        wr(8'h08, 2'd2, 32'd0);
        wr(8'h0C, 2'd2, 32'h1122_3344);
        chk("R2 combined word", drv_feat, 64'hCAFE_F00D_1122_3344);
        wr(8'h0C, 2'd0, 32'h0000_00AA);
        chk("R2 R11 byte write to half 0", drv_feat, 64'hCAFE_F00D_1122_33AA);
        wr(8'h08, 2'd2, 32'd2);
        wr(8'h0C, 2'd2, 32'h9999_9999);
        chk("R2 select 2 write ignored", drv_feat, 64'hCAFE_F00D_1122_33AA);
        rd(8'h0C, 2'd2, 32'h0, "R2 select 2 reads zero");
        wr(8'h08, 2'd2, 32'd1);
        rd(8'h0C, 2'd2, 32'hCAFE_F00D, "R2 half 1 readback");

        // R3 and R5: queue select bound, notify offset
        wr(8'h16, 2'd1, 32'd2);
        rd(8'h1E, 2'd1, 32'd2, "R5 notify offset");
        wr(8'h16, 2'd1, 32'd3);
        rd(8'h16, 2'd1, 32'd2, "R3 select equal to count refused");
        wr(8'h16, 2'd1, 32'h0100);
        rd(8'h16, 2'd1, 32'd2, "R3 large select refused");

        // R6: staging on queue 2
        wr(8'h20, 2'd2, 32'h89AB_CDEF);
        wr(8'h24, 2'd2, 32'h0000_0001);
        wr(8'h28, 2'd2, 32'h2222_0000);
        wr(8'h2C, 2'd2, 32'h0000_0003);
        wr(8'h30, 2'd2, 32'h4444_0000);
        wr(8'h34, 2'd2, 32'h0000_0005);
        wr(8'h18, 2'd1, 32'h0000_0100);
        rd(8'h24, 2'd2, 32'h0000_0001, "R6 desc high staged");
        rd(8'h30, 2'd2, 32'h4444_0000, "R6 used low staged");
        chk("R7 not committed before enable", q_desc[2], 64'h0);
        rd(8'h18, 2'd1, 32'h0, "R4 size reads committed value");
        rd(8'h12, 2'd1, 32'h0, "R4 count before commit");

        // R11: byte lanes
        wr(8'h21, 2'd0, 32'h0000_0055);
        rd(8'h21, 2'd0, 32'h0000_0055, "R11 byte read");
        rd(8'h22, 2'd1, 32'h0000_89AB, "R11 half-word read at offset 2");
        rd(8'h20, 2'd2, 32'h89AB_55EF, "R11 byte write merged");

        // R7: commit on enable
        wr(8'h1C, 2'd1, 32'd1);
        chk("R7 commit pulse", 64'(q_commit), 64'b100);
        chk("R7 size", 64'(q_size[2]), 64'h100);
        chk("R7 desc", q_desc[2], 64'h0000_0001_89AB_55EF);
        chk("R7 avail", q_avail[2], 64'h0000_0003_2222_0000);
        chk("R7 used", q_used[2], 64'h0000_0005_4444_0000);
        chk("R7 enable flag", 64'(q_en), 64'b100);
        @(negedge clk);
        chk("R7 pulse one cycle", 64'(q_commit), 64'h0);
        rd(8'h12, 2'd1, 32'd3, "R4 count after commit");
        rd(8'h18, 2'd1, 32'h100, "R4 committed size");
        rd(8'h1C, 2'd1, 32'd1, "R7 enable readback");
        wr(8'h20, 2'd2, 32'h0);
        chk("R7 staging change not visible", q_desc[2], 64'h0000_0001_89AB_55EF);

        wr(8'h16, 2'd1, 32'd0);
        wr(8'h18, 2'd1, 32'h0040);
        wr(8'h1C, 2'd1, 32'd0);
        chk("R7 commit queue 0", 64'(q_commit), 64'b001);
        chk("R7 size queue 0", 64'(q_size[0]), 64'h40);
        chk("R7 queue 2 untouched", 64'(q_size[2]), 64'h100);
        chk("R7 enable bit from data", 64'(q_en), 64'b100);
        rd(8'h12, 2'd1, 32'd3, "R4 highest index governs");
        rd(8'h1E, 2'd1, 32'd0, "R5 notify offset queue 0");

        // R9: vector allocation
        wr(8'h10, 2'd1, 32'd4);
        chk("R9 cfg vector at limit-1", 64'(cfg_vec), 64'd4);
        wr(8'h10, 2'd1, 32'd5);
        chk("R9 cfg vector refused", 64'(cfg_vec), 64'hFFFF);
        wr(8'h10, 2'd1, 32'd4);
        wr(8'h16, 2'd1, 32'd2);
        wr(8'h1A, 2'd1, 32'd3);
        chk("R9 queue vector granted", 64'(q_vec[2]), 64'd3);
        rd(8'h1A, 2'd1, 32'd3, "R9 queue vector readback");
        wr(8'h1A, 2'd1, 32'd9);
        chk("R9 queue vector refused", 64'(q_vec[2]), 64'hFFFF);
        wr(8'h1A, 2'd1, 32'd4);

        // R10: read-only and unmapped offsets
        rd(8'h15, 2'd0, 32'h0, "R10 generation byte");
        rd(8'h3C, 2'd2, 32'h0, "R10 unmapped read");
        wr(8'h3C, 2'd2, 32'hFFFF_FFFF);
        rd(8'h3C, 2'd2, 32'h0, "R10 unmapped write ignored");
        wr(8'h1E, 2'd1, 32'd1);
        chk("R10 notify write no commit", 64'(q_commit), 64'h0);
        rd(8'h1E, 2'd1, 32'd2, "R10 notify write ignored");
        wr(8'h12, 2'd1, 32'd0);
        rd(8'h12, 2'd1, 32'd3, "R10 queue count write ignored");
        wr(8'h00, 2'd2, 32'd0);
        wr(8'h04, 2'd2, 32'h0);
        rd(8'h04, 2'd2, 32'h1234_5678, "R10 feature data write ignored");

        // R8: status and device reset
        wr(8'h14, 2'd0, 32'h0F);
        chk("R8 status stored", 64'(status), 64'h0F);
        chk("R8 no reset on nonzero", 64'(dev_reset), 64'h0);
        rd(8'h14, 2'd0, 32'h0F, "R8 status readback");
        wr(8'h14, 2'd2, 32'h0001_0100);
        chk("R8 reset pulse", 64'(dev_reset), 64'h1);
        chk("R8 status zero", 64'(status), 64'h0);
        chk("R8 cfg vector released", 64'(cfg_vec), 64'hFFFF);
        chk("R8 queue vectors released", 64'(q_vec), {16'h0, {3{16'hFFFF}}});
        chk("R8 enables cleared", 64'(q_en), 64'h0);
        @(negedge clk);
        chk("R8 pulse one cycle", 64'(dev_reset), 64'h0);
        rd(8'h1E, 2'd1, 32'd1, "R3 select written with status word");
        rd(8'h12, 2'd1, 32'd3, "R8 committed sizes kept");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++; n_err++;
            $display("FAIL R11 missing responses actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        finish_run();
    end

endmodule